// File: doc/BRIEF.md
# SDRAM Low-Power Sequencer

This block sits between the access scheduler of an SDRAM controller and the SDRAM command pins. While the scheduler has no work for the memory, the block puts the device into one of three low-power states and brings it back when work arrives. The three states are self refresh, power-down and deep power-down. In self refresh the device keeps its own contents. In power-down the block itself keeps the contents alive with periodic auto refresh. In deep power-down, which only mobile parts offer, the contents are lost.

A two-bit mode input selects the state. A two-bit timeout input sets how long the memory must stay idle before self refresh or power-down is entered. The block drives clock enable and the chip-select, row-strobe, column-strobe and write-enable pins while it owns the bus. Its grant output tells the outside multiplexer when the access path may drive the pins instead.

Leaving deep power-down does not return the bus to the access path. The block instead raises a flag asking for the device to be initialised again, and waits until the initialisation is reported done.

Top module: `sdram_lp_seq`

## Requirements
- R1: During and after reset, grant is 1, busy is 0, reinit_req is 0, clock enable is 1, and the command is NOP. Commands are written as {cs_n,ras_n,cas_n,we_n}; NOP is 0111.
- R2: Idle cycles are those in which acc_req is low while grant is 1. Each cycle with acc_req high restarts the idle count. The timeout code sets the idle wait T: code 0 gives T=0, code 1 gives 64, code 2 gives 128 and code 3 gives 256. Grant falls at the clock edge that ends idle cycle T+1.
- R3: Mode code 0 means disabled, 1 self refresh, 2 power-down and 3 deep power-down. With code 0, grant stays 1 and clock enable stays high however long the memory is idle.
- R4: Every entry sequence opens with one precharge-all cycle: command 0010 with sd_a10 high. It is followed by T_RP-1 NOP cycles.
- R5: Self refresh is entered with a refresh command (0001) while clock enable is low. Clock enable then stays low until acc_req rises. The exit raises clock enable and sends T_XSR NOP cycles, and grant returns in the cycle after that.
- R6: Power-down is entered by dropping clock enable with a NOP. When acc_req rises, clock enable goes high for one NOP cycle and grant returns in the next cycle.
- R7: While in power-down, after REF_INT cycles of holding, the block raises clock enable for one NOP cycle and issues a refresh (0001) with clock enable high. It then sends T_RC-1 NOP cycles. After that it either drops clock enable again or, if acc_req is high, grants. Grant never returns fewer than T_RC cycles after a refresh.
- R8: Deep power-down ignores the timeout and is entered with a burst-terminate command (0110) while clock enable is low. When acc_req rises, clock enable goes high for T_DPDX NOP cycles. Then reinit_req rises with grant still 0. Grant returns, and reinit_req falls, in the cycle after reinit_done is seen high.
- R9: Busy is 1 and grant is 0 during every entry, exit and power-down refresh cycle. Busy is 0 while the device is held in a low-power state and while reinit_req is high.
- R10: The mode is captured when entry starts. Changes to cfg_mode made during an entry sequence or a hold do not change that entry or its exit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Low-power mode code (R3) |
| cfg_timeout | input | 2 | Idle timeout code (R2) |
| acc_req | input | 1 | Scheduler has an access for the device |
| reinit_done | input | 1 | Device initialisation finished after deep power-down |
| grant | output | 1 | Access path owns the command pins |
| busy | output | 1 | Entry, exit or refresh sequence in progress |
| reinit_req | output | 1 | Device needs re-initialisation |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_a10 | output | 1 | Address bit 10, high for precharge-all |

## Verification
The hardest case to reach is a power-down refresh where an access arrives during the row-cycle wait that follows the refresh. The exit must then hold grant back until the full T_RC has passed, instead of dropping clock enable again. To reach it, the bench parks the device in power-down and counts hold cycles exactly to the internal refresh tick. It raises acc_req in the cycle of the refresh command and then counts cycles until grant appears. The bench also restarts the 64-cycle idle window with a one-cycle access in its middle, to show that the count starts over.

// File: rtl/sdram_lp_pkg.sv
package sdram_lp_pkg;

    typedef enum logic [1:0] {
        LPM_OFF = 2'd0,
        LPM_SR  = 2'd1,
        LPM_PD  = 2'd2,
        LPM_DPD = 2'd3
    } lp_mode_e;

    typedef enum logic [3:0] {
        ST_ACTIVE,
        ST_PRE,
        ST_TRP,
        ST_SR_ENTRY,
        ST_SR_HOLD,
        ST_SR_EXIT,
        ST_PD_HOLD,
        ST_PD_EXIT,
        ST_PD_WAKE,
        ST_PD_REF,
        ST_TRC,
        ST_DPD_ENTRY,
        ST_DPD_HOLD,
        ST_DPD_EXIT,
        ST_REINIT
    } lp_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sd_cmd_t;

    localparam sd_cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sd_cmd_t CMD_PRE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam sd_cmd_t CMD_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
    localparam sd_cmd_t CMD_BST = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b0};

    localparam int IDLE_W = 9;

    function automatic logic [IDLE_W-1:0] timeout_cycles(input logic [1:0] code);
        logic [IDLE_W-1:0] r;
        case (code)
            2'd1:    r = IDLE_W'(64);
            2'd2:    r = IDLE_W'(128);
            2'd3:    r = IDLE_W'(256);
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lp_idle_timer.sv
module lp_idle_timer #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt != {CNT_W{1'b1}}) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt >= limit);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (cnt == {CNT_W{1'b1}}) |=> (cnt == {CNT_W{1'b1}} || cnt == '0)); // R2

endmodule

// File: rtl/lp_ref_timer.sv
module lp_ref_timer #(
    parameter int REF_INT = 780
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int W = $clog2(REF_INT) + 1;
    localparam logic [W-1:0] LAST = W'(REF_INT - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);

    AST_REF_RANGE: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt <= LAST)); // R7

endmodule

// File: rtl/lp_wait_cnt.sv
module lp_wait_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/sdram_lp_seq.sv
module sdram_lp_seq
    import sdram_lp_pkg::*;
#(
    parameter int T_RP    = 3,
    parameter int T_RC    = 8,
    parameter int T_XSR   = 10,
    parameter int T_DPDX  = 20,
    parameter int REF_INT = 780
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] cfg_mode,
    input  logic [1:0] cfg_timeout,
    input  logic       acc_req,
    input  logic       reinit_done,
    output logic       grant,
    output logic       busy,
    output logic       reinit_req,
    output logic       sd_cke,
    output logic       sd_cs_n,
    output logic       sd_ras_n,
    output logic       sd_cas_n,
    output logic       sd_we_n,
    output logic       sd_a10
);
    localparam int MAX_WAIT = imax(imax(T_RP, T_RC), imax(T_XSR, T_DPDX));
    localparam int WAIT_W   = $clog2(MAX_WAIT + 1);
    localparam int SREF_W   = $clog2(T_RC + 1);

    lp_state_e         state, state_nxt;
    lp_mode_e          mode_q;
    logic              idle_expired;
    logic              ref_tick;
    logic              wait_zero;
    logic              wait_load;
    logic [WAIT_W-1:0] wait_val;
    logic [IDLE_W-1:0] idle_limit;
    sd_cmd_t           cmd;

    // Deep power-down enters at once; the other modes wait out the timeout.
    assign idle_limit = (lp_mode_e'(cfg_mode) == LPM_DPD) ? '0 : timeout_cycles(cfg_timeout);

    lp_idle_timer #(.CNT_W(IDLE_W)) u_idle (
        .clk     (clk),
        .rst     (rst),
        .run     (state == ST_ACTIVE && !acc_req),
        .limit   (idle_limit),
        .expired (idle_expired)
    );

    lp_ref_timer #(.REF_INT(REF_INT)) u_ref (
        .clk  (clk),
        .rst  (rst),
        .run  (state == ST_PD_HOLD),
        .tick (ref_tick)
    );

    lp_wait_cnt #(.W(WAIT_W)) u_wait (
        .clk      (clk),
        .rst      (rst),
        .load     (wait_load),
        .load_val (wait_val),
        .zero     (wait_zero)
    );

    always_comb begin
        state_nxt = state;
        case (state)
            ST_ACTIVE:    if (lp_mode_e'(cfg_mode) != LPM_OFF && idle_expired) state_nxt = ST_PRE;
            ST_PRE:       state_nxt = ST_TRP;
            ST_TRP: begin
                if (wait_zero) begin
                    case (mode_q)
                        LPM_SR:  state_nxt = ST_SR_ENTRY;
                        LPM_PD:  state_nxt = ST_PD_HOLD;
                        LPM_DPD: state_nxt = ST_DPD_ENTRY;
                        default: state_nxt = ST_ACTIVE;
                    endcase
                end
            end
            ST_SR_ENTRY:  state_nxt = ST_SR_HOLD;
            ST_SR_HOLD:   if (acc_req) state_nxt = ST_SR_EXIT;
            ST_SR_EXIT:   if (wait_zero) state_nxt = ST_ACTIVE;
            ST_PD_HOLD: begin
                if (acc_req)       state_nxt = ST_PD_EXIT;
                else if (ref_tick) state_nxt = ST_PD_WAKE;
            end
            ST_PD_EXIT:   state_nxt = ST_ACTIVE;
            ST_PD_WAKE:   state_nxt = ST_PD_REF;
            ST_PD_REF:    state_nxt = ST_TRC;
            ST_TRC:       if (wait_zero) state_nxt = acc_req ? ST_ACTIVE : ST_PD_HOLD;
            ST_DPD_ENTRY: state_nxt = ST_DPD_HOLD;
            ST_DPD_HOLD:  if (acc_req) state_nxt = ST_DPD_EXIT;
            ST_DPD_EXIT:  if (wait_zero) state_nxt = ST_REINIT;
            ST_REINIT:    if (reinit_done) state_nxt = ST_ACTIVE;
            default:      state_nxt = ST_ACTIVE;
        endcase
    end

    // Timed states are loaded with their length minus one on entry.
    always_comb begin
        wait_load = (state_nxt != state);
        case (state_nxt)
            ST_TRP:      wait_val = WAIT_W'(T_RP - 2);
            ST_SR_EXIT:  wait_val = WAIT_W'(T_XSR - 1);
            ST_TRC:      wait_val = WAIT_W'(T_RC - 2);
            ST_DPD_EXIT: wait_val = WAIT_W'(T_DPDX - 1);
            default:     wait_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_ACTIVE;
            mode_q <= LPM_OFF;
        end else begin
            state <= state_nxt;
            if (state == ST_ACTIVE && state_nxt == ST_PRE) begin
                mode_q <= lp_mode_e'(cfg_mode);
            end
        end
    end

    always_comb begin
        cmd        = CMD_NOP;
        sd_a10     = 1'b0;
        sd_cke     = 1'b1;
        grant      = 1'b0;
        busy       = 1'b1;
        reinit_req = 1'b0;
        case (state)
            ST_ACTIVE: begin
                grant = 1'b1;
                busy  = 1'b0;
            end
            ST_PRE: begin
                cmd    = CMD_PRE;
                sd_a10 = 1'b1;
            end
            ST_SR_ENTRY: begin
                cmd    = CMD_REF;
                sd_cke = 1'b0;
            end
            ST_SR_HOLD, ST_PD_HOLD, ST_DPD_HOLD: begin
                sd_cke = 1'b0;
                busy   = 1'b0;
            end
            ST_PD_REF:    cmd = CMD_REF;
            ST_DPD_ENTRY: begin
                cmd    = CMD_BST;
                sd_cke = 1'b0;
            end
            ST_REINIT: begin
                busy       = 1'b0;
                reinit_req = 1'b1;
            end
            default: ;
        endcase
    end

    assign sd_cs_n  = cmd.cs_n;
    assign sd_ras_n = cmd.ras_n;
    assign sd_cas_n = cmd.cas_n;
    assign sd_we_n  = cmd.we_n;

    // Cycles since the last refresh issued with clock enable high.
    logic [SREF_W-1:0] since_ref;
    always_ff @(posedge clk) begin
        if (rst) begin
            since_ref <= SREF_W'(T_RC);
        end else if (cmd == CMD_REF && sd_cke) begin
            since_ref <= SREF_W'(1);
        end else if (since_ref != SREF_W'(T_RC)) begin
            since_ref <= since_ref + 1'b1;
        end
    end

    AST_IDLE_ENTRY: assert property (@(posedge clk) disable iff (rst)
        $fell(grant) |-> $past(!acc_req)); // R2
    AST_MODE_OFF_STAYS: assert property (@(posedge clk) disable iff (rst)
        $past(grant && cfg_mode == 2'd0) |-> grant); // R3
    AST_TRP_GAP: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_PRE) |=> (cmd == CMD_NOP && !grant)); // R4
    AST_REF_TO_GRANT: assert property (@(posedge clk) disable iff (rst)
        $rose(grant) |-> (since_ref >= SREF_W'(T_RC))); // R7
    AST_REINIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (reinit_req && !reinit_done) |=> (reinit_req && !grant)); // R8
    AST_GRANT_CKE: assert property (@(posedge clk) disable iff (rst)
        grant |-> (sd_cke && !busy)); // R9

endmodule

// File: tb/test_sdram_lp_seq.sv
module test_sdram_lp_seq;
    localparam int T_RP    = 3;
    localparam int T_RC    = 8;
    localparam int T_XSR   = 6;
    localparam int T_DPDX  = 5;
    localparam int REF_INT = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cfg_mode = 2'd0;
    logic [1:0] cfg_timeout = 2'd0;
    logic       acc_req = 1'b1;
    logic       reinit_done = 1'b0;
    logic       grant, busy, reinit_req, sd_cke;
    logic       sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_a10;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    sdram_lp_seq #(
        .T_RP(T_RP), .T_RC(T_RC), .T_XSR(T_XSR), .T_DPDX(T_DPDX), .REF_INT(REF_INT)
    ) i_sdram_lp_seq (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_timeout(cfg_timeout),
        .acc_req(acc_req), .reinit_done(reinit_done), .grant(grant), .busy(busy),
        .reinit_req(reinit_req), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_a10(sd_a10)
    );

    localparam logic [3:0] NOP = 4'b0111;
    localparam logic [3:0] PRE = 4'b0010;
    localparam logic [3:0] REF = 4'b0001;
    localparam logic [3:0] BST = 4'b0110;

    function automatic logic [3:0] cmd_now();
        return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) step();
        chk("R1", "grant in reset", int'(grant), 1);
        chk("R1", "busy in reset", int'(busy), 0);
        rst = 1'b0;
        step();
        chk("R1", "reinit after reset", int'(reinit_req), 0);
        chk("R1", "cke after reset", int'(sd_cke), 1);
        chk("R1", "cmd after reset", int'(cmd_now()), int'(NOP));
    endtask

    task automatic t_disabled();
        cfg_mode = 2'd0;
        cfg_timeout = 2'd0;
        acc_req = 1'b0;
        repeat (300) step();
        chk("R3", "grant while disabled", int'(grant), 1);
        chk("R3", "cke while disabled", int'(sd_cke), 1);
        acc_req = 1'b1;
        step();
    endtask

    task automatic t_self_refresh();
        cfg_mode = 2'd1;
        cfg_timeout = 2'd0;
        acc_req = 1'b0;
        step();
        chk("R4", "precharge cmd", int'(cmd_now()), int'(PRE));
        chk("R4", "a10 on precharge", int'(sd_a10), 1);
        chk("R9", "busy on entry", int'(busy), 1);
        chk("R9", "grant on entry", int'(grant), 0);
        for (int i = 0; i < T_RP - 1; i++) begin
            step();
            chk("R4", "nop after precharge", int'(cmd_now()), int'(NOP));
        end
        step();
        chk("R5", "self refresh cmd", int'(cmd_now()), int'(REF));
        chk("R5", "cke on entry", int'(sd_cke), 0);
        repeat (6) step();
        chk("R5", "cke in hold", int'(sd_cke), 0);
        chk("R9", "busy in hold", int'(busy), 0);
        acc_req = 1'b1;
        step();
        chk("R5", "cke on exit", int'(sd_cke), 1);
        chk("R5", "nop on exit", int'(cmd_now()), int'(NOP));
        chk("R9", "busy on exit", int'(busy), 1);
        repeat (T_XSR - 1) step();
        chk("R5", "grant before txsr done", int'(grant), 0);
        step();
        chk("R5", "grant after exit", int'(grant), 1);
        chk("R9", "busy after exit", int'(busy), 0);
    endtask

    task automatic sr_leave();
        repeat (T_RP + 1) step();
        acc_req = 1'b1;
        repeat (T_XSR + 1) step();
        chk("R5", "grant after sr leave", int'(grant), 1);
    endtask

    task automatic t_timeout();
        cfg_mode = 2'd1;
        cfg_timeout = 2'd1;
        acc_req = 1'b0;
        repeat (40) step();
        acc_req = 1'b1;
        step();
        acc_req = 1'b0;
        repeat (64) step();
        chk("R2", "grant at 64 idle after restart", int'(grant), 1);
        step();
        chk("R2", "grant after 65 idle", int'(grant), 0);
        chk("R2", "precharge after timeout", int'(cmd_now()), int'(PRE));
        sr_leave();
        cfg_timeout = 2'd3;
        acc_req = 1'b0;
        repeat (256) step();
        chk("R2", "grant at 256 idle", int'(grant), 1);
        step();
        chk("R2", "grant after 257 idle", int'(grant), 0);
        sr_leave();
    endtask

    task automatic t_power_down();
        cfg_mode = 2'd2;
        cfg_timeout = 2'd0;
        acc_req = 1'b0;
        repeat (T_RP + 1) step();
        chk("R6", "cke low in pd", int'(sd_cke), 0);
        chk("R6", "nop on pd entry", int'(cmd_now()), int'(NOP));
        repeat (REF_INT - 1) step();
        chk("R7", "cke still low before tick", int'(sd_cke), 0);
        step();
        chk("R7", "cke raised before refresh", int'(sd_cke), 1);
        chk("R7", "nop before refresh", int'(cmd_now()), int'(NOP));
        chk("R9", "busy on pd wake", int'(busy), 1);
        step();
        chk("R7", "refresh cmd", int'(cmd_now()), int'(REF));
        chk("R7", "cke on refresh", int'(sd_cke), 1);
        repeat (T_RC - 1) step();
        chk("R7", "nop during trc", int'(cmd_now()), int'(NOP));
        chk("R7", "cke during trc", int'(sd_cke), 1);
        step();
        chk("R7", "cke low after trc", int'(sd_cke), 0);
        // second refresh with an access arriving at the refresh cycle
        repeat (REF_INT - 1) step();
        step();
        step();
        chk("R7", "second refresh cmd", int'(cmd_now()), int'(REF));
        acc_req = 1'b1;
        repeat (T_RC - 1) step();
        chk("R7", "no grant inside trc", int'(grant), 0);
        step();
        chk("R7", "grant at trc", int'(grant), 1);
        // exit straight from hold
        acc_req = 1'b0;
        repeat (T_RP + 1) step();
        chk("R6", "cke low re-entered", int'(sd_cke), 0);
        acc_req = 1'b1;
        step();
        chk("R6", "cke high on exit", int'(sd_cke), 1);
        chk("R6", "no grant on exit cycle", int'(grant), 0);
        step();
        chk("R6", "grant after pd exit", int'(grant), 1);
    endtask

    task automatic t_deep();
        cfg_mode = 2'd3;
        cfg_timeout = 2'd3;
        acc_req = 1'b0;
        step();
        chk("R8", "immediate precharge", int'(cmd_now()), int'(PRE));
        repeat (T_RP - 1) step();
        step();
        chk("R8", "bst cmd", int'(cmd_now()), int'(BST));
        chk("R8", "cke on dpd entry", int'(sd_cke), 0);
        repeat (4) step();
        chk("R8", "cke in dpd hold", int'(sd_cke), 0);
        acc_req = 1'b1;
        step();
        chk("R8", "cke on dpd exit", int'(sd_cke), 1);
        chk("R9", "busy on dpd exit", int'(busy), 1);
        repeat (T_DPDX - 1) step();
        chk("R8", "reinit not yet", int'(reinit_req), 0);
        step();
        chk("R8", "reinit raised", int'(reinit_req), 1);
        chk("R8", "no grant in reinit", int'(grant), 0);
        chk("R9", "busy in reinit", int'(busy), 0);
        repeat (4) step();
        chk("R8", "reinit held", int'(reinit_req), 1);
        reinit_done = 1'b1;
        step();
        reinit_done = 1'b0;
        chk("R8", "grant after reinit", int'(grant), 1);
        chk("R8", "reinit cleared", int'(reinit_req), 0);
    endtask

    task automatic t_cfg_latch();
        cfg_mode = 2'd1;
        cfg_timeout = 2'd0;
        acc_req = 1'b0;
        step();
        cfg_mode = 2'd2;
        repeat (T_RP) step();
        chk("R10", "sr entry kept", int'(cmd_now()), int'(REF));
        step();
        cfg_mode = 2'd3;
        repeat (3) step();
        chk("R10", "cke low in hold", int'(sd_cke), 0);
        acc_req = 1'b1;
        repeat (T_XSR + 1) step();
        chk("R10", "sr exit grant", int'(grant), 1);
        chk("R10", "no reinit", int'(reinit_req), 0);
    endtask

    initial begin
        t_reset();
        t_disabled();
        t_self_refresh();
        t_timeout();
        t_power_down();
        t_deep();
        t_cfg_latch();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule